// File: doc/BRIEF.md
# SMRAM Size Negotiation Register

This block is a small register pair in a host bridge's configuration space. Firmware uses it to find out, and then to choose, how large the protected system-management memory region is. A discovery register lets firmware learn a size that the platform set in megabytes. A control register holds a two-bit select. That select picks one of three fixed sizes, or the platform size. The block turns the selection into a size in bytes. It also gives a region base, which sits that many bytes below the top of low memory.

Firmware talks to the block through a request channel and a response channel. The request channel uses valid/ready. `req_ready` is always high, so every request is taken in the cycle its `req_valid` is high, and the block never applies back-pressure. A read gives one response pulse on `rsp_valid` in the next cycle. The response channel has no ready signal, so the consumer must take the data in that cycle. A write gives no response. The platform size is a static input, 12 bits wide, so its largest value is 4095 MB and the byte size always fits in 32 bits. The usual platform setting is 16 MB.

Top module: `smram_size_ctl`

## Requirements
- R1: While reset is active, the discovery register is loaded with `ext_mbytes`, which is zero when that input is zero. The select is loaded with 00. `region_size` resets to 0x0010_0000 and `region_base` resets to 0.
- R2: The discovery register is 16 bits wide and is read at dword address 0x14 (byte offset 0x50) on bits [15:0]. Bits [31:16] of that dword read as zero. On a write, `req_be[0]` updates bits [7:0] only and `req_be[1]` updates bits [15:8] only. A bit whose byte enable is low keeps its value.
- R3: If a write to the discovery register leaves the value 0xFFFF and `ext_mbytes` is not zero, the register takes `ext_mbytes`. A later read then returns that value.
- R4: If `ext_mbytes` is zero, a write that leaves 0xFFFF is stored as 0xFFFF and is read back as 0xFFFF.
- R5: Any other value written to the discovery register is stored exactly as written and read back the same way.
- R6: The select is read and written at dword address 0x27 (byte offset 0x9C) on bits [1:0]. A write changes it only when `req_be[0]` is high. Bits [31:2] of that dword read as zero.
- R7: Select 00 gives a size of 1 MB, select 01 gives 2 MB and select 10 gives 8 MB. The size in bytes is the size in megabytes shifted left by 20.
- R8: Select 11 gives a size of `ext_mbytes` shifted left by 20 when `ext_mbytes` is not zero. When `ext_mbytes` is zero, select 11 stays reserved and gives a size of 0.
- R9: `region_size` and `region_base` are registers. At every clock edge they load the size for the select as it stands after that edge's write, and they load `tolm` minus that size, using `tolm` as sampled at the same edge.
- R10: `req_ready` is always 1. Each read gives `rsp_valid` high for exactly one cycle, in the cycle after the read is accepted. A write never gives a response. A dword other than 0x14 or 0x27 reads as zero, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, always 1 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 6 | Dword address, which is byte offset bits [7:2] |
| req_be | input | 4 | Byte enables for a write |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, high for one cycle |
| rsp_rdata | output | 32 | Read response data |
| ext_mbytes | input | 12 | Platform extended size in megabytes (static) |
| tolm | input | 32 | Top of low memory in bytes |
| region_size | output | 32 | Selected region size in bytes |
| region_base | output | 32 | Region base, equal to tolm minus the size |

## Verification
Two things can meet at the same clock edge: a write to the select, and a change in `tolm`. Both feed the registered region outputs. The bench drives a new random `tolm` value in the same cycle as every request, including every select write. It then checks one cycle later that `region_base` equals the new `tolm` minus the size for the new select, so neither input is allowed to lag. Tests of the discovery query use platform sizes of 0, 16 and 4095. These tests mix full-word and single-byte writes, because a single-byte write can also complete the 0xFFFF pattern.

// File: rtl/smram_pkg.sv
package smram_pkg;

  localparam int MB_W     = 16;
  localparam int MB_SHIFT = 20;
  localparam int DISC_W   = 16;
  localparam logic [7:0] DISC_BYTE_OFS = 8'h50;
  localparam logic [7:0] CTRL_BYTE_OFS = 8'h9C;
  localparam logic [DISC_W-1:0] QUERY_PATTERN = 16'hFFFF;

  typedef enum logic [1:0] {
    SEL_1M  = 2'b00,
    SEL_2M  = 2'b01,
    SEL_8M  = 2'b10,
    SEL_EXT = 2'b11
  } size_sel_e;

  function automatic logic [MB_W-1:0] sel_to_mb(size_sel_e s, logic [MB_W-1:0] ext);
    logic [MB_W-1:0] r;
    case (s)
      SEL_1M:  r = MB_W'(1);
      SEL_2M:  r = MB_W'(2);
      SEL_8M:  r = MB_W'(8);
      default: r = ext;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/smram_cfg_regs.sv
module smram_cfg_regs
  import smram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int EXT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW/8-1:0]   be,
  input  logic [DW-1:0]     wdata,
  input  logic [EXT_W-1:0]  ext_mb,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [DISC_W-1:0] disc_q,
  output size_sel_e         sel_q,
  output size_sel_e         sel_d
);

  localparam int DISC_BYTES = DISC_W / 8;
  localparam logic [AW-1:0] DISC_DW = AW'(DISC_BYTE_OFS >> 2);
  localparam logic [AW-1:0] CTRL_DW = AW'(CTRL_BYTE_OFS >> 2);

  logic              hit_disc, hit_ctrl, ext_nz;
  logic [DISC_W-1:0] disc_merged, disc_d, ext_wide;
  logic              unused_bits;

  assign hit_disc = (addr == DISC_DW);
  assign hit_ctrl = (addr == CTRL_DW);
  assign ext_wide = DISC_W'(ext_mb);
  assign ext_nz   = (ext_mb != '0);

  // per-lane merge of write data into the discovery register
  for (genvar b = 0; b < DISC_BYTES; b++) begin : g_lane
    assign disc_merged[8*b +: 8] = be[b] ? wdata[8*b +: 8] : disc_q[8*b +: 8];
  end

  always_comb begin
    disc_d = disc_q;
    if (wr_en && hit_disc) begin
      if (disc_merged == QUERY_PATTERN && ext_nz) disc_d = ext_wide;
      else                                        disc_d = disc_merged;
    end
  end

  always_comb begin
    sel_d = sel_q;
    if (wr_en && hit_ctrl && be[0]) sel_d = size_sel_e'(wdata[1:0]);
  end

  assign unused_bits = ^{wdata[DW-1:DISC_W], be[DW/8-1:DISC_BYTES]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disc_q    <= ext_wide;
      sel_q     <= SEL_1M;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      disc_q    <= disc_d;
      sel_q     <= sel_d;
      rsp_valid <= rd_en;
      if (rd_en) begin
        if (hit_disc)      rsp_rdata <= DW'(disc_q);
        else if (hit_ctrl) rsp_rdata <= DW'(sel_q);
        else               rsp_rdata <= '0;
      end
    end
  end

endmodule

// File: rtl/smram_size_dec.sv
module smram_size_dec
  import smram_pkg::*;
#(
  parameter int RW    = 32,
  parameter int EXT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  size_sel_e        sel,
  input  logic [EXT_W-1:0] ext_mb,
  input  logic [RW-1:0]    tolm,
  output logic [RW-1:0]    size_q,
  output logic [RW-1:0]    base_q
);

  localparam logic [RW-1:0] RESET_SIZE = RW'(1) << MB_SHIFT;

  logic [MB_W-1:0] mb;
  logic [RW-1:0]   size_d;

  assign mb     = sel_to_mb(sel, MB_W'(ext_mb));
  assign size_d = RW'(mb) << MB_SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= RESET_SIZE;
      base_q <= '0;
    end else begin
      size_q <= size_d;
      base_q <= tolm - size_d;
    end
  end

endmodule

// File: rtl/smram_size_ctl.sv
module smram_size_ctl
  import smram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int RW    = 32,
  parameter int EXT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW/8-1:0]  req_be,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  input  logic [EXT_W-1:0] ext_mbytes,
  input  logic [RW-1:0]    tolm,
  output logic [RW-1:0]    region_size,
  output logic [RW-1:0]    region_base
);

  logic              wr_en, rd_en;
  logic [DISC_W-1:0] disc_q;
  size_sel_e         sel_q, sel_d;

  assign req_ready = 1'b1;
  assign wr_en     = req_valid &  req_write;
  assign rd_en     = req_valid & ~req_write;

  smram_cfg_regs #(.AW(AW), .DW(DW), .EXT_W(EXT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (req_addr),
    .be        (req_be),
    .wdata     (req_wdata),
    .ext_mb    (ext_mbytes),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .disc_q    (disc_q),
    .sel_q     (sel_q),
    .sel_d     (sel_d)
  );

  smram_size_dec #(.RW(RW), .EXT_W(EXT_W)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel_d),
    .ext_mb (ext_mbytes),
    .tolm   (tolm),
    .size_q (region_size),
    .base_q (region_base)
  );

endmodule

// File: rtl/smram_size_chk.sv
module smram_size_chk
  import smram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int RW    = 32,
  parameter int EXT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [AW-1:0]     req_addr,
  input logic [DW/8-1:0]   req_be,
  input logic [DW-1:0]     req_wdata,
  input logic              rsp_valid,
  input logic [EXT_W-1:0]  ext_mbytes,
  input logic [RW-1:0]     tolm,
  input logic [RW-1:0]     region_size,
  input logic [RW-1:0]     region_base,
  input logic [DISC_W-1:0] disc_q
);

  localparam logic [AW-1:0] DISC_DW = AW'(DISC_BYTE_OFS >> 2);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  logic [RW-1:0] ext_bytes;
  assign ext_bytes = RW'(ext_mbytes) << MB_SHIFT;

  AST_BASE_PLUS_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (region_base + region_size == $past(tolm))); // R9

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (region_size == (RW'(1) << MB_SHIFT)) || (region_size == (RW'(2) << MB_SHIFT)) ||
    (region_size == (RW'(8) << MB_SHIFT)) || (region_size == ext_bytes)); // R7

  AST_ZERO_ONLY_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (region_size == '0) |-> (ext_mbytes == '0)); // R8

  AST_QUERY_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == DISC_DW && req_be[1:0] == 2'b11 &&
     req_wdata[15:0] == QUERY_PATTERN && ext_mbytes != '0)
    |=> (disc_q == DISC_W'(ext_mbytes))); // R3

  AST_DISC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_addr == DISC_DW) |=> $stable(disc_q)); // R2

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R10

  AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write)); // R10

endmodule

bind smram_size_ctl smram_size_chk #(.AW(AW), .DW(DW), .RW(RW), .EXT_W(EXT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_be      (req_be),
  .req_wdata   (req_wdata),
  .rsp_valid   (rsp_valid),
  .ext_mbytes  (ext_mbytes),
  .tolm        (tolm),
  .region_size (region_size),
  .region_base (region_base),
  .disc_q      (disc_q)
);

// File: tb/smram_size_ctl_test.sv
`timescale 1ns/1ps
module smram_size_ctl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [11:0] ext_mbytes = 12'd16;
  logic [31:0] tolm = 32'h8000_0000;
  logic [31:0] region_size, region_base;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [15:0] disc_m;
  logic [1:0]  sel_m;

  localparam logic [5:0] A_DISC = 6'h14;
  localparam logic [5:0] A_CTRL = 6'h27;

  always #2.5 clk = ~clk;

  smram_size_ctl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ext_mbytes(ext_mbytes), .tolm(tolm),
    .region_size(region_size), .region_base(region_base)
  );

  function automatic logic [31:0] exp_size(logic [1:0] s, logic [11:0] e);
    case (s)
      2'b00:   return 32'd1 << 20;
      2'b01:   return 32'd2 << 20;
      2'b10:   return 32'd8 << 20;
      default: return 32'(e) << 20;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(logic [5:0] a);
    if (a == A_DISC) return {16'h0, disc_m};
    if (a == A_CTRL) return {30'h0, sel_m};
    return 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [11:0] e);
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; ext_mbytes = e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    disc_m = 16'(e); sel_m = 2'b00;
    check("R1 size", region_size, 32'd1 << 20);
    check("R1 base", region_base, 32'h0);
  endtask

  // one request; starts and ends at a negedge
  task automatic op(bit wr, logic [5:0] a, logic [3:0] be, logic [31:0] d, string tag);
    logic [31:0] rexp;
    logic [15:0] merged;
    rexp = exp_read(a);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    tolm = $urandom;
    check("R10 ready", {31'h0, req_ready}, 32'h1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      if (a == A_DISC) begin
        merged = disc_m;
        if (be[0]) merged[7:0]  = d[7:0];
        if (be[1]) merged[15:8] = d[15:8];
        disc_m = (merged == 16'hFFFF && ext_mbytes != 0) ? 16'(ext_mbytes) : merged;
      end else if (a == A_CTRL && be[0]) begin
        sel_m = d[1:0];
      end
      check({tag, " R10 no rsp"}, {31'h0, rsp_valid}, 32'h0);
    end else begin
      check({tag, " R10 rsp_valid"}, {31'h0, rsp_valid}, 32'h1);
      check({tag, " rdata"}, rsp_rdata, rexp);
    end
    check({tag, " R7 R8 size"}, region_size, exp_size(sel_m, ext_mbytes));
    check({tag, " R9 base"}, region_base, tolm - exp_size(sel_m, ext_mbytes));
  endtask

  task automatic random_ops(int n);
    for (int i = 0; i < n; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 4)
        op(1, A_DISC, 4'($urandom), ($urandom_range(0, 1) != 0) ? 32'hFFFF_FFFF : $urandom, "R2 R3 R5 rnd");
      else if (k < 6)
        op(1, A_CTRL, 4'($urandom), $urandom, "R6 rnd");
      else if (k < 7)
        op(1, 6'($urandom), 4'hF, $urandom, "R10 rnd");
      else if (k < 8)
        op(0, 6'($urandom), 4'h0, 0, "R10 rnd");
      else
        op(0, ($urandom_range(0, 1) != 0) ? A_DISC : A_CTRL, 4'h0, 0, "R2 R6 rnd");
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    // platform size 16
    do_reset(12'd16);
    op(0, A_DISC, 4'h0, 0, "R1 disc");
    op(0, A_CTRL, 4'h0, 0, "R1 sel");
    op(1, A_DISC, 4'hF, 32'hFFFF_FFFF, "R3 query");
    op(0, A_DISC, 4'h0, 0, "R3 readback");
    op(1, A_DISC, 4'hF, 32'hABCD_1234, "R5 store");
    op(0, A_DISC, 4'h0, 0, "R5 R2 readback");
    op(1, A_DISC, 4'h1, 32'h0000_00EE, "R2 low byte");
    op(0, A_DISC, 4'h0, 0, "R2 low readback");
    op(1, A_DISC, 4'h2, 32'h0000_7700, "R2 high byte");
    op(0, A_DISC, 4'h0, 0, "R2 high readback");
    op(1, A_DISC, 4'h1, 32'h0000_00FF, "R2 partial");
    op(1, A_DISC, 4'h2, 32'h0000_FF00, "R3 byte query");
    op(0, A_DISC, 4'h0, 0, "R3 byte readback");
    op(1, A_CTRL, 4'h1, 32'hFFFF_FF01, "R7 sel 01");
    op(1, A_CTRL, 4'h1, 32'h0000_0002, "R7 sel 10");
    op(1, A_CTRL, 4'h1, 32'h0000_0003, "R8 sel 11");
    op(0, A_CTRL, 4'h0, 0, "R6 readback");
    op(1, A_CTRL, 4'hE, 32'h0000_0000, "R6 be0 off");
    op(1, A_CTRL, 4'h1, 32'h0000_0000, "R7 sel 00");
    op(1, 6'h15, 4'hF, 32'hFFFF_FFFF, "R10 unmapped wr");
    op(0, 6'h15, 4'h0, 0, "R10 unmapped rd");
    op(0, A_DISC, 4'h0, 0, "R10 unmapped no effect");
    random_ops(300);
    // platform size 0
    do_reset(12'd0);
    op(0, A_DISC, 4'h0, 0, "R1 zero disc");
    op(1, A_DISC, 4'h3, 32'h0000_FFFF, "R4 query");
    op(0, A_DISC, 4'h0, 0, "R4 readback");
    op(1, A_CTRL, 4'h1, 32'h0000_0003, "R8 reserved");
    random_ops(300);
    // platform size at cap
    do_reset(12'd4095);
    op(1, A_DISC, 4'h3, 32'h0000_FFFF, "R3 cap query");
    op(0, A_DISC, 4'h0, 0, "R3 cap readback");
    op(1, A_CTRL, 4'h1, 32'h0000_0003, "R8 cap size");
    random_ops(300);
    // random nonzero size
    do_reset(12'($urandom_range(1, 4095)));
    random_ops(300);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule